// File: doc/BRIEF.md
# Per-Lane Programmable QAM Amplitude Slicer

This block decides one real dimension of a symbol for many lanes at once during one expansion stage of a breadth-first tree search. Each lane takes a 16-bit two's complement sample and returns the nearest constellation amplitude from a four-entry table. The lane builds the table index from the sample's sign and from whether its magnitude reaches a shared threshold. The slow sequence of absolute value, compare, select and conditional negate is replaced by a single registered table lookup.

The table is the same in every lane and is programmed by broadcast. A reload strobe rebuilds all four entries from an inner and an outer amplitude. A single-entry write port can also place any value in any entry. In 16-QAM mode the index uses both the sign and the threshold decision. In QPSK mode only the sign picks the entry. A small valid tracker has two states. VS_IDLE moves to VS_EMIT when `in_valid` is high, and VS_EMIT stays in VS_EMIT while `in_valid` stays high. Either state goes to VS_IDLE when `in_valid` is low. `out_valid` is high only in VS_EMIT.

Top module: `qam_slicer`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_sym` is 0. Each lane's table holds +UNIT, +3·UNIT, −UNIT, −3·UNIT at indices 0, 1, 2, 3, with UNIT = 256 by default.
- R2: In 16-QAM mode (`mode` = 0), the table index is {neg, big}. Index bit 1 is neg, which is 1 when the sample is negative. Index bit 0 is big, which is 1 when the sample's magnitude is at or above `thresh` (unsigned compare). The lane output is the entry at that index.
- R3: A sample of zero counts as non-negative. The sample −32768 has a magnitude of 32768.
- R4: In QPSK mode (`mode` = 1), the index is {neg, 0}, so the magnitude has no effect on the output.
- R5: A write with `tbl_wr` high stores `tbl_data` at `tbl_addr` in every lane. Samples taken in the same cycle still see the old contents. Samples taken from the next cycle on see the new value.
- R6: With `amp_load` high, the table becomes {+`amp_inner`, +`amp_outer`, −`amp_inner`, −`amp_outer`} at indices 0 to 3, negated in two's complement. This reload takes priority over a `tbl_wr` in the same cycle, and that write is dropped.
- R7: `out_valid` is `in_valid` delayed by exactly one cycle. `out_sym` is the result for the samples taken at that edge.
- R8: While `in_valid` is low, `out_sym` holds its value and `in_data` has no effect on it.
- R9: Each lane slices only its own sample, found at `in_data[l*16 +: 16]` for lane l. All lanes use the shared mode, threshold and table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Samples present this cycle |
| in_data | input | LANES*DW | Packed lane samples, lane 0 in the low bits |
| mode | input | 1 | 0 = 16-QAM, 1 = QPSK |
| thresh | input | DW | Unsigned magnitude threshold |
| amp_inner | input | DW | Inner amplitude for reload |
| amp_outer | input | DW | Outer amplitude for reload |
| amp_load | input | 1 | Rebuild the table from the two amplitudes |
| tbl_wr | input | 1 | Single-entry broadcast write strobe |
| tbl_addr | input | 2 | Entry index for the write |
| tbl_data | input | DW | Entry value for the write |
| out_valid | output | 1 | Sliced symbols present |
| out_sym | output | LANES*DW | Packed sliced symbols |

## Verification
The hardest case is the same-cycle race between table programming and slicing. The bench reaches it by raising `tbl_wr` or `amp_load` on the same edge as a sample vector. It expects the old entry for that vector and the new entry for the vector right behind it. It also raises both strobes together to show that the reload wins. Magnitude ties are reached by placing each sample at the threshold, one below it, and at the same points negated. The −32768 corner and sweeps at thresholds 0 and 20000 are also driven. Bubbles are inserted between back-to-back vectors, with junk on the data bus, to show that the output holds.

// File: rtl/qs_pkg.sv
package qs_pkg;
    localparam int TBL_DEPTH = 4;
    localparam int TBL_AW    = 2;

    typedef enum logic {
        MODE_QAM16 = 1'b0,
        MODE_QPSK  = 1'b1
    } slice_mode_e;

    typedef enum logic {
        VS_IDLE = 1'b0,
        VS_EMIT = 1'b1
    } vstate_e;
endpackage

// File: rtl/qs_addr_gen.sv
module qs_addr_gen
    import qs_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0]     sample,
    input  logic [DW-1:0]     thresh,
    input  slice_mode_e       mode,
    output logic [TBL_AW-1:0] addr
);
    logic          neg;
    logic [DW-1:0] mag;
    logic          big;

    always_comb begin
        neg = sample[DW-1];
        // unsigned magnitude; the most negative value maps to 2^(DW-1)
        mag = neg ? (~sample + {{(DW-1){1'b0}}, 1'b1}) : sample;
        big = (mag >= thresh);
        unique case (mode)
            MODE_QAM16: addr = {neg, big};
            MODE_QPSK:  addr = {neg, 1'b0};
            default:    addr = {neg, big};
        endcase
    end
endmodule

// File: rtl/qs_sym_table.sv
module qs_sym_table
    import qs_pkg::*;
#(
    parameter int DW   = 16,
    parameter int UNIT = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              amp_load,
    input  logic [DW-1:0]     amp_inner,
    input  logic [DW-1:0]     amp_outer,
    input  logic              wr_en,
    input  logic [TBL_AW-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [TBL_AW-1:0] rd_addr,
    output logic [DW-1:0]     rd_data
);
    localparam logic [DW-1:0] P1 = DW'(UNIT);
    localparam logic [DW-1:0] P3 = DW'(3 * UNIT);
    localparam logic [DW-1:0] N1 = DW'(-UNIT);
    localparam logic [DW-1:0] N3 = DW'(-3 * UNIT);

    logic [DW-1:0] entry_q [TBL_DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_q[0] <= P1;
            entry_q[1] <= P3;
            entry_q[2] <= N1;
            entry_q[3] <= N3;
        end else if (amp_load) begin
            entry_q[0] <= amp_inner;
            entry_q[1] <= amp_outer;
            entry_q[2] <= ~amp_inner + {{(DW-1){1'b0}}, 1'b1};
            entry_q[3] <= ~amp_outer + {{(DW-1){1'b0}}, 1'b1};
        end else if (wr_en) begin
            entry_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = entry_q[rd_addr];

    // R5: a lone write lands in the addressed entry
    p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !amp_load) |=> entry_q[$past(wr_addr)] == $past(wr_data));

    // R6: reload places the amplitude and its negation
    p_reload_inner_r6: assert property (@(posedge clk) disable iff (!rst_n)
        amp_load |=> entry_q[0] == $past(amp_inner));
    p_reload_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        amp_load |=> (DW'(entry_q[3] + $past(amp_outer)) == {DW{1'b0}}));
endmodule

// File: rtl/qs_lane.sv
module qs_lane
    import qs_pkg::*;
#(
    parameter int DW   = 16,
    parameter int UNIT = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DW-1:0]     sample,
    input  logic [DW-1:0]     thresh,
    input  slice_mode_e       mode,
    input  logic              amp_load,
    input  logic [DW-1:0]     amp_inner,
    input  logic [DW-1:0]     amp_outer,
    input  logic              wr_en,
    input  logic [TBL_AW-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     sym
);
    logic [TBL_AW-1:0] idx;
    logic [DW-1:0]     entry;
    logic [DW-1:0]     sym_q;

    qs_addr_gen #(.DW(DW)) i_addr (
        .sample (sample),
        .thresh (thresh),
        .mode   (mode),
        .addr   (idx)
    );

    qs_sym_table #(.DW(DW), .UNIT(UNIT)) i_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .amp_load  (amp_load),
        .amp_inner (amp_inner),
        .amp_outer (amp_outer),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (idx),
        .rd_data   (entry)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_q <= '0;
        end else if (capture) begin
            sym_q <= entry;
        end
    end

    assign sym = sym_q;
endmodule

// File: rtl/qs_valid_fsm.sv
module qs_valid_fsm
    import qs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic out_valid
);
    vstate_e state_q;
    vstate_e state_d;

    always_comb begin
        unique case (state_q)
            VS_IDLE: state_d = in_valid ? VS_EMIT : VS_IDLE;
            VS_EMIT: state_d = in_valid ? VS_EMIT : VS_IDLE;
            default: state_d = VS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= VS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            VS_IDLE: out_valid = 1'b0;
            VS_EMIT: out_valid = 1'b1;
            default: out_valid = 1'b0;
        endcase
    end

    // R7: valid follows input valid after exactly one edge
    p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
endmodule

// File: rtl/qam_slicer.sv
module qam_slicer
    import qs_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DW    = 16,
    parameter int UNIT  = 256
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [LANES*DW-1:0]   in_data,
    input  logic                  mode,
    input  logic [DW-1:0]         thresh,
    input  logic [DW-1:0]         amp_inner,
    input  logic [DW-1:0]         amp_outer,
    input  logic                  amp_load,
    input  logic                  tbl_wr,
    input  logic [1:0]            tbl_addr,
    input  logic [DW-1:0]         tbl_data,
    output logic                  out_valid,
    output logic [LANES*DW-1:0]   out_sym
);
    localparam int SW = LANES * DW;

    slice_mode_e   mode_e;
    logic [DW-1:0] lane_sym [LANES];

    assign mode_e = slice_mode_e'(mode);

    qs_valid_fsm i_vfsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_valid (out_valid)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        qs_lane #(.DW(DW), .UNIT(UNIT)) i_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .capture   (in_valid),
            .sample    (in_data[l*DW +: DW]),
            .thresh    (thresh),
            .mode      (mode_e),
            .amp_load  (amp_load),
            .amp_inner (amp_inner),
            .amp_outer (amp_outer),
            .wr_en     (tbl_wr),
            .wr_addr   (tbl_addr),
            .wr_data   (tbl_data),
            .sym       (lane_sym[l])
        );
    end

    always_comb begin
        out_sym = {SW{1'b0}};
        for (int l = 0; l < LANES; l++) begin
            out_sym[l*DW +: DW] = lane_sym[l];
        end
    end

    // R8: no new samples means the sliced vector holds
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_sym));
endmodule

// File: tb/test_qam_slicer.sv
module test_qam_slicer;
    localparam int LANES = 4;
    localparam int DW    = 16;
    localparam int UNIT  = 256;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic [LANES*DW-1:0] in_data = '0;
    logic                mode = 1'b0;
    logic [DW-1:0]       thresh = '0;
    logic [DW-1:0]       amp_inner = '0;
    logic [DW-1:0]       amp_outer = '0;
    logic                amp_load = 1'b0;
    logic                tbl_wr = 1'b0;
    logic [1:0]          tbl_addr = '0;
    logic [DW-1:0]       tbl_data = '0;
    logic                out_valid;
    logic [LANES*DW-1:0] out_sym;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    int model [4];

    always #2.5 clk = ~clk;

    qam_slicer #(.LANES(LANES), .DW(DW), .UNIT(UNIT)) i_qam_slicer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .mode(mode), .thresh(thresh), .amp_inner(amp_inner),
        .amp_outer(amp_outer), .amp_load(amp_load), .tbl_wr(tbl_wr),
        .tbl_addr(tbl_addr), .tbl_data(tbl_data), .out_valid(out_valid),
        .out_sym(out_sym)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] slice(input logic [DW-1:0] x);
        int v   = int'($signed(x));
        int m   = (v < 0) ? -v : v;
        int neg = (v < 0) ? 1 : 0;
        int big = (m >= int'(thresh)) ? 1 : 0;
        int idx = mode ? neg * 2 : neg * 2 + big;
        return DW'(model[idx]);
    endfunction

    // called at a negedge; leaves at the negedge after the capture edge
    task automatic apply(input logic [LANES*DW-1:0] d, input string req);
        logic [LANES*DW-1:0] exp;
        for (int l = 0; l < LANES; l++) exp[l*DW +: DW] = slice(d[l*DW +: DW]);
        in_valid = 1'b1;
        in_data  = d;
        @(posedge clk);
        @(negedge clk);
        chk("R7 valid", {63'd0, out_valid}, 64'd1);
        chk(req, out_sym, exp);
        in_valid = 1'b0;
        tbl_wr   = 1'b0;
        amp_load = 1'b0;
    endtask

    task automatic bubble(input logic [LANES*DW-1:0] junk);
        logic [LANES*DW-1:0] prev = out_sym;
        in_valid = 1'b0;
        in_data  = junk;
        @(posedge clk);
        @(negedge clk);
        chk("R8 hold", out_sym, prev);
        chk("R7 idle", {63'd0, out_valid}, 64'd0);
    endtask

    function automatic logic [LANES*DW-1:0] pack(input int a, input int b, input int c, input int d);
        return {DW'(d), DW'(c), DW'(b), DW'(a)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        model[0] = UNIT; model[1] = 3 * UNIT; model[2] = -UNIT; model[3] = -3 * UNIT;
        repeat (4) @(negedge clk);
        chk("R1 valid", {63'd0, out_valid}, 64'd0);
        chk("R1 sym", out_sym, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after", {63'd0, out_valid}, 64'd0);

        // default table and tie handling, 16-QAM
        thresh = 16'd1000;
        mode   = 1'b0;
        apply(pack(0, 999, 1000, -1000), "R1 R2 R3 ties");
        apply(pack(-999, -32768, 32767, -1), "R2 R3 corners");
        bubble(pack(7000, -7000, 1, -1));

        // sweeps over threshold and mode, lanes offset (R9)
        for (int t = 0; t < 3; t++) begin
            thresh = (t == 0) ? 16'd0 : (t == 1) ? 16'd1000 : 16'd20000;
            for (int md = 0; md < 2; md++) begin
                mode = md[0];
                for (int k = 0; k < 129; k++) begin
                    int b = -32768 + k * 509;
                    apply(pack(b, b + 127, b + 254, b + 381), md ? "R4 R9 qpsk sweep" : "R2 R9 qam sweep");
                    if (k % 16 == 0) bubble(pack(k, -k, 3 * k, 12345));
                end
            end
        end

        // R5: write seen only by the next vector
        mode = 1'b0;
        thresh = 16'd1000;
        tbl_wr = 1'b1; tbl_addr = 2'd1; tbl_data = 16'h1234;
        apply(pack(1500, 1500, -5, 5), "R5 same-cycle old");
        model[1] = 16'h1234;
        apply(pack(1500, 2000, -1500, 5), "R5 next-cycle new");

        // R6: reload with a competing write
        amp_inner = 16'd100; amp_outer = 16'd300; amp_load = 1'b1;
        tbl_wr = 1'b1; tbl_addr = 2'd0; tbl_data = 16'h7777;
        apply(pack(5, 2000, -5, -2000), "R6 same-cycle old");
        model[0] = 100; model[1] = 300; model[2] = -100; model[3] = -300;
        apply(pack(5, 2000, -5, -2000), "R6 reload priority");
        mode = 1'b1;
        apply(pack(5, 2000, -5, -2000), "R4 qpsk reloaded");
        apply(pack(0, -32768, 32767, -1), "R3 R4 qpsk corners");
        bubble('1);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule